// File: doc/BRIEF.md
# Accumulator Processor Control Sequencer

This block is a very small one-address processor built around a single accumulator. A control state machine walks every instruction through a chain of single-cycle register transfers among the program counter, the memory address register, the memory data register, the instruction register and the accumulator. It drives a synchronous, word-addressed memory port and reads back data one cycle after presenting an address.

Each 16-bit instruction word holds an opcode in its upper byte and a memory address in its lower byte. Four operations are defined: copy a memory word into the accumulator, add a memory word to it, write it to memory, and stop. An addition that leaves the signed range latches an overflow flag. After every load, add or store the sequencer passes through an interrupt-check state. If the flag is set there, it stops with an abnormal-end indication. Otherwise it returns to fetch.

The states are named as follows. The fetch chain is FETCH_ADDR (MAR takes PC), FETCH_WAIT (memory read in flight), FETCH_DATA (MDR takes read data), FETCH_IR (IR takes MDR) and FETCH_INC (PC increments and the opcode is decoded). The operand chain is EXEC_ADDR (MAR takes the address field), EXEC_WAIT and EXEC_DATA. LOAD_ACC and ADD_ACC write the accumulator. STORE_DATA (MDR takes A) and STORE_WRITE (write strobe) perform a store. The remaining states are IRQ_CHECK, STOPPED and ABENDED.

The transitions are as follows. Each fetch state leads to the next one. FETCH_INC branches to EXEC_ADDR for load, add or store, to STOPPED for end, and to IRQ_CHECK for any other code. EXEC_ADDR branches to STORE_DATA for a store and to EXEC_WAIT otherwise. EXEC_DATA branches to ADD_ACC or LOAD_ACC. LOAD_ACC, ADD_ACC and STORE_WRITE all lead to IRQ_CHECK. IRQ_CHECK goes to ABENDED when the overflow flag is set and to FETCH_ADDR otherwise. STOPPED and ABENDED hold until reset.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous active-high reset clears PC, MAR, MDR, IR, the accumulator, the overflow flag, `halted` and `abend`, so that execution begins by fetching address 0.
- R2: A fetch takes five cycles. The read address comes from MAR, the read data arrives one cycle later, and PC advances by one per fetched word.
- R3: An instruction word is {opcode[15:8], address[7:0]}. Opcode 0x01 (load) copies MEM[address] into the accumulator.
- R4: Opcode 0x02 (add) sets the accumulator to accumulator + MEM[address], modulo 2^16.
- R5: Opcode 0x03 (store) writes the accumulator to MEM[address] with a write strobe one cycle long, exactly once per store.
- R6: An add whose operands share a sign that differs from the sign of the sum sets the overflow flag. A carry out without signed overflow leaves it clear.
- R7: Every load, add and store is followed by the interrupt check. If the flag is set, the block raises `halted` and `abend` and performs no further fetch or write.
- R8: Opcode 0x04 (end) raises `halted` with `abend` low.
- R9: `halted` and `abend` stay high until reset, and no memory write occurs while halted.
- R10: Any other opcode, 0x00 included, changes no register other than PC and IR, passes through the interrupt check, and takes 6 cycles.
- R11: Load and add take 10 cycles, store takes 9, and an end instruction halts on the 5th edge after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory word address (MAR) |
| mem_wdata | output | 16 | Memory write data (MDR) |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| halted | output | 1 | Machine has stopped |
| abend | output | 1 | Machine stopped on overflow |

## Verification
Two things can happen on the same clock edge: the accumulator takes the wrapped sum, and the overflow flag is latched. The very next state, IRQ_CHECK, then has to act on that flag before the following store is fetched. The bench provokes this by adding at the positive limit and at the negative limit, with a store to a sentinel word after the add. It also adds at the boundaries where there is a carry but no overflow. It judges each case by the abend output, by the exact cycle count to halt, and by whether the sentinel word survives.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int unsigned OPC_LOAD  = 1;
    localparam int unsigned OPC_ADD   = 2;
    localparam int unsigned OPC_STORE = 3;
    localparam int unsigned OPC_END   = 4;

    typedef enum logic [3:0] {
        ST_FETCH_ADDR,
        ST_FETCH_WAIT,
        ST_FETCH_DATA,
        ST_FETCH_IR,
        ST_FETCH_INC,
        ST_EXEC_ADDR,
        ST_EXEC_WAIT,
        ST_EXEC_DATA,
        ST_LOAD_ACC,
        ST_ADD_ACC,
        ST_STORE_DATA,
        ST_STORE_WRITE,
        ST_IRQ_CHECK,
        ST_STOPPED,
        ST_ABENDED
    } seq_state_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mdr_from_mem;
        logic mdr_from_acc;
        logic ir_from_mdr;
        logic pc_inc;
        logic acc_from_mdr;
        logic acc_from_sum;
    } dp_ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         ovf
);
    always_comb begin
        sum = a + b;
        ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
    import acc_cpu_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] op,
    input  logic            ovf,
    output seq_state_e      state,
    output dp_ctrl_t        ctrl,
    output logic            mem_we,
    output logic            halted,
    output logic            abend
);
    localparam logic [OP_W-1:0] OP_LOAD  = OP_W'(OPC_LOAD);
    localparam logic [OP_W-1:0] OP_ADD   = OP_W'(OPC_ADD);
    localparam logic [OP_W-1:0] OP_STORE = OP_W'(OPC_STORE);
    localparam logic [OP_W-1:0] OP_END   = OP_W'(OPC_END);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH_ADDR;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH_ADDR:  state_d = ST_FETCH_WAIT;
            ST_FETCH_WAIT:  state_d = ST_FETCH_DATA;
            ST_FETCH_DATA:  state_d = ST_FETCH_IR;
            ST_FETCH_IR:    state_d = ST_FETCH_INC;
            ST_FETCH_INC: begin
                if (op == OP_LOAD || op == OP_ADD || op == OP_STORE)
                    state_d = ST_EXEC_ADDR;
                else if (op == OP_END)
                    state_d = ST_STOPPED;
                else
                    state_d = ST_IRQ_CHECK;
            end
            ST_EXEC_ADDR:   state_d = (op == OP_STORE) ? ST_STORE_DATA : ST_EXEC_WAIT;
            ST_EXEC_WAIT:   state_d = ST_EXEC_DATA;
            ST_EXEC_DATA:   state_d = (op == OP_ADD) ? ST_ADD_ACC : ST_LOAD_ACC;
            ST_LOAD_ACC:    state_d = ST_IRQ_CHECK;
            ST_ADD_ACC:     state_d = ST_IRQ_CHECK;
            ST_STORE_DATA:  state_d = ST_STORE_WRITE;
            ST_STORE_WRITE: state_d = ST_IRQ_CHECK;
            ST_IRQ_CHECK:   state_d = ovf ? ST_ABENDED : ST_FETCH_ADDR;
            ST_STOPPED:     state_d = ST_STOPPED;
            ST_ABENDED:     state_d = ST_ABENDED;
            default:        state_d = ST_FETCH_ADDR;
        endcase
    end

    always_comb begin
        ctrl   = '0;
        mem_we = 1'b0;
        halted = 1'b0;
        abend  = 1'b0;
        unique case (state_q)
            ST_FETCH_ADDR:  ctrl.mar_from_pc  = 1'b1;
            ST_FETCH_DATA:  ctrl.mdr_from_mem = 1'b1;
            ST_FETCH_IR:    ctrl.ir_from_mdr  = 1'b1;
            ST_FETCH_INC:   ctrl.pc_inc       = 1'b1;
            ST_EXEC_ADDR:   ctrl.mar_from_ir  = 1'b1;
            ST_EXEC_DATA:   ctrl.mdr_from_mem = 1'b1;
            ST_LOAD_ACC:    ctrl.acc_from_mdr = 1'b1;
            ST_ADD_ACC:     ctrl.acc_from_sum = 1'b1;
            ST_STORE_DATA:  ctrl.mdr_from_acc = 1'b1;
            ST_STORE_WRITE: mem_we            = 1'b1;
            ST_STOPPED:     halted            = 1'b1;
            ST_ABENDED: begin
                halted = 1'b1;
                abend  = 1'b1;
            end
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter int OP_W  = 8,
    parameter int ADR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  dp_ctrl_t                ctrl,
    input  logic [OP_W+ADR_W-1:0]   mem_rdata,
    output logic [ADR_W-1:0]        mem_addr,
    output logic [OP_W+ADR_W-1:0]   mem_wdata,
    output logic [OP_W-1:0]         op,
    output logic [ADR_W-1:0]        pc,
    output logic                    ovf
);
    localparam int W = OP_W + ADR_W;

    logic [ADR_W-1:0] pc_q, mar_q;
    logic [W-1:0]     mdr_q, ir_q, acc_q, sum_w;
    logic             ovf_q, add_ovf_w;

    acc_cpu_alu #(.W(W)) u_alu (
        .a   (acc_q),
        .b   (mdr_q),
        .sum (sum_w),
        .ovf (add_ovf_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (ctrl.mar_from_pc)  mar_q <= pc_q;
            if (ctrl.mar_from_ir)  mar_q <= ir_q[ADR_W-1:0];
            if (ctrl.mdr_from_mem) mdr_q <= mem_rdata;
            if (ctrl.mdr_from_acc) mdr_q <= acc_q;
            if (ctrl.ir_from_mdr)  ir_q  <= mdr_q;
            if (ctrl.pc_inc)       pc_q  <= pc_q + ADR_W'(1);
            if (ctrl.acc_from_mdr) acc_q <= mdr_q;
            if (ctrl.acc_from_sum) begin
                acc_q <= sum_w;
                if (add_ovf_w) ovf_q <= 1'b1;
            end
        end
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;
    assign op        = ir_q[W-1 -: OP_W];
    assign pc        = pc_q;
    assign ovf       = ovf_q;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int OP_W  = 8,
    parameter int ADR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    output logic [ADR_W-1:0]      mem_addr,
    output logic [OP_W+ADR_W-1:0] mem_wdata,
    output logic                  mem_we,
    input  logic [OP_W+ADR_W-1:0] mem_rdata,
    output logic                  halted,
    output logic                  abend
);
    seq_state_e       state_w;
    dp_ctrl_t         ctrl_w;
    logic [OP_W-1:0]  op_w;
    logic [ADR_W-1:0] pc_w;
    logic             ovf_w;

    acc_cpu_seq #(.OP_W(OP_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .op     (op_w),
        .ovf    (ovf_w),
        .state  (state_w),
        .ctrl   (ctrl_w),
        .mem_we (mem_we),
        .halted (halted),
        .abend  (abend)
    );

    acc_cpu_dp #(.OP_W(OP_W), .ADR_W(ADR_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_w),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .op        (op_w),
        .pc        (pc_w),
        .ovf       (ovf_w)
    );
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
#(
    parameter int ADR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_we,
    input logic             halted,
    input logic             abend,
    input seq_state_e       state,
    input logic             ovf,
    input logic [ADR_W-1:0] pc
);
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    a_r9_abend_sticky: assert property (@(posedge clk) disable iff (rst)
        abend |=> abend);

    a_r9_no_write_halted: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);

    a_r7_abend_halted: assert property (@(posedge clk) disable iff (rst)
        abend |-> halted);

    a_r5_we_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    a_r7_check_abend: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IRQ_CHECK && ovf) |=> abend);

    a_r7_check_fetch: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IRQ_CHECK && !ovf) |=> (state == ST_FETCH_ADDR));

    a_r2_pc_inc: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH_INC) |=> (pc == $past(pc) + ADR_W'(1)));
endmodule

bind acc_cpu acc_cpu_chk #(.ADR_W(ADR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .mem_we (mem_we),
    .halted (halted),
    .abend  (abend),
    .state  (state_w),
    .ovf    (ovf_w),
    .pc     (pc_w)
);

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata = '0;
    logic        halted;
    logic        abend;

    logic [15:0] mem [256];
    int checks = 0;
    int fails = 0;
    int we_count = 0;

    always #4 clk = ~clk;

    acc_cpu u_dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted),
        .abend     (abend)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
        if (!rst && mem_we) we_count <= we_count + 1;
    end

    function automatic logic [15:0] ins(input logic [7:0] op, input logic [7:0] a);
        return {op, a};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic boot();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
        @(negedge clk);
    endtask

    task automatic run(output int n);
        @(negedge clk);
        rst = 1'b0;
        n = 0;
        while (!halted && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_sum();
        int n, w0;
        boot();
        mem[0] <= ins(8'h01, 8'h20); mem[1] <= ins(8'h02, 8'h21);
        mem[2] <= ins(8'h03, 8'h22); mem[3] <= ins(8'h04, 8'h00);
        mem[8'h20] <= 16'd450; mem[8'h21] <= 16'd300;
        w0 = we_count;
        run(n);
        check(mem[8'h22] == 16'd750, "R3/R4/R5 sum stored", mem[8'h22], 750);
        check(halted && !abend, "R8 normal end", {halted, abend}, 2'b10);
        check(we_count - w0 == 1, "R5 one strobe per store", we_count - w0, 1);
        check(n == 34, "R11 program cycles", n, 34);
    endtask

    task automatic t_timing();
        int n;
        boot();
        mem[0] <= ins(8'h01, 8'h10); mem[1] <= ins(8'h04, 8'h00);
        run(n);
        check(n == 15, "R2/R11 load then end cycles", n, 15);
    endtask

    task automatic t_ovf(input logic [15:0] a, input logic [15:0] b, input string tag);
        int n, w0;
        boot();
        mem[0] <= ins(8'h01, 8'h20); mem[1] <= ins(8'h02, 8'h21);
        mem[2] <= ins(8'h03, 8'h30); mem[3] <= ins(8'h04, 8'h00);
        mem[8'h20] <= a; mem[8'h21] <= b; mem[8'h30] <= 16'hAAAA;
        w0 = we_count;
        run(n);
        check(halted && abend, {"R6/R7 abend ", tag}, {halted, abend}, 2'b11);
        check(n == 20, {"R7 abend cycle ", tag}, n, 20);
        check(mem[8'h30] == 16'hAAAA && we_count == w0, {"R7 no store after abend ", tag}, mem[8'h30], 16'hAAAA);
    endtask

    task automatic t_boundary();
        int n;
        boot();
        mem[0] <= ins(8'h01, 8'h20); mem[1] <= ins(8'h02, 8'h21); mem[2] <= ins(8'h03, 8'h30);
        mem[3] <= ins(8'h01, 8'h22); mem[4] <= ins(8'h02, 8'h23); mem[5] <= ins(8'h03, 8'h31);
        mem[6] <= ins(8'h04, 8'h00);
        mem[8'h20] <= 16'h7FFE; mem[8'h21] <= 16'h0001;
        mem[8'h22] <= 16'hFFFF; mem[8'h23] <= 16'h0001;
        mem[8'h31] <= 16'h5555;
        run(n);
        check(mem[8'h30] == 16'h7FFF, "R4 sum at positive limit", mem[8'h30], 16'h7FFF);
        check(mem[8'h31] == 16'h0000, "R4 wrap to zero", mem[8'h31], 0);
        check(halted && !abend, "R6 carry is not overflow", {halted, abend}, 2'b10);
    endtask

    task automatic t_sticky();
        int w0;
        w0 = we_count;
        repeat (40) @(negedge clk);
        check(halted && we_count == w0, "R9 halt held, no writes", {halted, 1'b0}, 2'b10);
    endtask

    task automatic t_sticky_abend();
        repeat (40) @(negedge clk);
        check(halted && abend, "R9 abend held", {halted, abend}, 2'b11);
    endtask

    task automatic t_reset();
        int n;
        boot();
        check(!halted && !abend && !mem_we, "R1 flags cleared", {halted, abend, mem_we}, 0);
        check(mem_addr == 8'h00, "R1 address cleared", mem_addr, 0);
        mem[0] <= ins(8'h03, 8'h40); mem[1] <= ins(8'h04, 8'h00);
        mem[8'h40] <= 16'h1234;
        run(n);
        check(mem[8'h40] == 16'h0000, "R1 accumulator cleared", mem[8'h40], 0);
        check(halted && !abend, "R1 overflow flag cleared", {halted, abend}, 2'b10);
        check(n == 14, "R11 store then end cycles", n, 14);
    endtask

    task automatic t_unknown();
        int n, w0;
        boot();
        mem[0] <= ins(8'h01, 8'h20); mem[1] <= ins(8'h09, 8'h30);
        mem[2] <= ins(8'h00, 8'h31); mem[3] <= ins(8'h03, 8'h22);
        mem[4] <= ins(8'h04, 8'h00);
        mem[8'h20] <= 16'd5; mem[8'h30] <= 16'hAAAA; mem[8'h31] <= 16'hBBBB;
        w0 = we_count;
        run(n);
        check(mem[8'h22] == 16'd5, "R10 accumulator untouched", mem[8'h22], 5);
        check(mem[8'h30] == 16'hAAAA && mem[8'h31] == 16'hBBBB, "R10 no write", mem[8'h30], 16'hAAAA);
        check(we_count - w0 == 1 && !abend, "R10 single store, no abend", we_count - w0, 1);
        check(n == 36, "R10 six cycles each", n, 36);
    endtask

    initial begin
        #1200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_sum();
        t_sticky();
        t_timing();
        t_ovf(16'h7FFF, 16'h0001, "positive");
        t_sticky_abend();
        t_ovf(16'h8000, 16'hFFFF, "negative");
        t_reset();
        t_boundary();
        t_unknown();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule